// File: doc/BRIEF.md
# Masked Ring Gather Reader

This block rebuilds one vertex ring (a concentric string of mesh vertices) from a wide vertex memory. Each memory word holds a fixed number of vertex slots. That number is one more than the largest vertex valence the mesh may have. A ring is rarely stored contiguously: it sits in pieces across several words. Each piece covers only part of a word.

For every ring, a small map lists the pieces in ring order. A map entry gives the word address, a slot mask, and a flag that marks the final piece. When a client asks for a ring, the reader walks that ring's map from entry zero. For each entry it fetches the word and moves the selected slots down to slot zero with a logarithmic barrel shifter. It then pushes the selected vertices, one per cycle, into an output FIFO. The last vertex of the ring carries an end flag. A downstream processor drains the FIFO through a valid/ready handshake. Write ports preload the vertex memory and the ring maps before the walks begin.

Top module: `string_gather_reader`

## Requirements
- R1: After reset, `busy` and `out_valid` are both low.
- R2: A request is accepted only when `busy` is low. A request raised while `busy` is high has no effect: the output carries only the vertices of the ring already being walked, and nothing follows them.
- R3: Map entries of the requested ring are visited in index order, from index 0. The walk ends after the entry whose end flag is set, or after the final map index.
- R4: Mask bit k selects slot k, and slot k occupies data bits [k*8 +: 8] of a word. The selected slots of one entry leave in rising slot order. A run that starts above slot 0 is output exactly like a run that starts at slot 0.
- R5: `out_last` is high only on the final vertex of the final entry of the walk.
- R6: With an empty FIFO, the first vertex appears two cycles after the accepting clock edge. While `out_ready` is high, the vertices of one entry arrive on consecutive cycles.
- R7: While `out_ready` is low, the head vertex and its flag stay stable and no vertex is lost. The walk stalls once the FIFO is full.
- R8: `busy` rises on the edge that accepts a request. It falls on the edge that pushes the final vertex, after which a new request can be accepted.
- R9: A map entry with an all-zero mask and no end flag contributes no vertices, and the walk goes on to the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_wr_en | input | 1 | Write one vertex-memory word |
| word_wr_addr | input | 4 | Vertex-memory word address |
| word_wr_data | input | 80 | Ten 8-bit vertex slots, slot k in bits [k*8 +: 8] |
| map_wr_en | input | 1 | Write one ring-map entry |
| map_wr_ring | input | 3 | Ring whose map is written |
| map_wr_idx | input | 4 | Entry index within the ring map |
| map_wr_addr | input | 4 | Vertex-memory word the entry points to |
| map_wr_mask | input | 10 | Slot mask; bit k selects slot k |
| map_wr_end | input | 1 | Entry is the final piece of the ring |
| req_valid | input | 1 | Request a ring walk |
| req_ring | input | 3 | Ring to walk |
| busy | output | 1 | A walk is in progress |
| out_valid | output | 1 | FIFO head holds a vertex |
| out_vertex | output | 8 | Head vertex identifier |
| out_last | output | 1 | Head vertex ends the ring |
| out_ready | input | 1 | Consumer takes the head vertex |

## Verification
The assertions assume that the map and the vertex memory are not written while a walk is in progress. They also assume that every mask picks out a contiguous run of slots, and that the entry carrying the end flag has a nonzero mask. The stimulus respects all three: it loads the whole memory and every map before the first request, and it uses only contiguous masks. The only empty mask it uses sits on an entry without the end flag. Consumer backpressure is exercised with periodic and sustained low-ready patterns. A request is also issued while another walk is still in progress.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

    localparam int SLOTS      = 10;
    localparam int VW         = 8;
    localparam int MEM_WORDS  = 16;
    localparam int MAP_LEN    = 16;
    localparam int NUM_RINGS  = 8;
    localparam int OUT_DEPTH  = 4;

    localparam int WORD_W = SLOTS * VW;
    localparam int ADDR_W = $clog2(MEM_WORDS);
    localparam int IDX_W  = $clog2(MAP_LEN);
    localparam int RING_W = $clog2(NUM_RINGS);
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int SH_W   = $clog2(SLOTS);

    typedef struct packed {
        logic              fin;
        logic [ADDR_W-1:0] addr;
        logic [SLOTS-1:0]  mask;
    } map_entry_t;

    typedef struct packed {
        logic          last;
        logic [VW-1:0] vertex;
    } out_item_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2
    } walk_state_t;

    function automatic logic [SH_W-1:0] first_slot(input logic [SLOTS-1:0] m);
        logic [SH_W-1:0] r;
        r = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (m[k]) r = SH_W'(k);
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] slot_count(input logic [SLOTS-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int k = 0; k < SLOTS; k++) begin
            n = n + CNT_W'(m[k]);
        end
        return n;
    endfunction

endpackage

// File: rtl/sgr_slot_compactor.sv
module sgr_slot_compactor
    import sgr_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [SLOTS-1:0]  mask_i,
    output logic [WORD_W-1:0] aligned_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [SH_W-1:0]   shift;
    logic [WORD_W-1:0] stage [SH_W+1];

    assign shift    = first_slot(mask_i);
    assign count_o  = slot_count(mask_i);
    assign stage[0] = word_i;

    for (genvar s = 0; s < SH_W; s++) begin : g_shift
        assign stage[s+1] = shift[s] ? (stage[s] >> ((1 << s) * VW)) : stage[s];
    end

    assign aligned_o = stage[SH_W];

endmodule

// File: rtl/sgr_out_fifo.sv
module sgr_out_fifo
    import sgr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  out_item_t item_i,
    input  logic      pop_i,
    output out_item_t head_o,
    output logic      valid_o,
    output logic      full_o
);

    localparam int PTR_W = $clog2(OUT_DEPTH);

    out_item_t        store_q [OUT_DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W:0]   cnt_q;
    logic             do_push;
    logic             do_pop;

    assign full_o  = (cnt_q == (PTR_W+1)'(OUT_DEPTH));
    assign valid_o = (cnt_q != '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && valid_o;
    assign head_o  = store_q[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_q] <= item_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/sgr_walker.sv
module sgr_walker
    import sgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [RING_W-1:0] req_ring_i,
    input  map_entry_t        entry_i,
    input  logic [WORD_W-1:0] aligned_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              full_i,
    output logic [RING_W-1:0] ring_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              busy_o,
    output logic              push_o,
    output out_item_t         item_o
);

    walk_state_t       state_q;
    logic [RING_W-1:0] ring_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] hold_q;
    logic [CNT_W-1:0]  left_q;
    logic              final_q;
    logic              final_entry;

    assign final_entry = entry_i.fin || (idx_q == IDX_W'(MAP_LEN - 1));

    assign ring_o        = ring_q;
    assign idx_o         = idx_q;
    assign busy_o        = (state_q != ST_IDLE);
    assign push_o        = (state_q == ST_EMIT) && !full_i;
    assign item_o.vertex = hold_q[VW-1:0];
    assign item_o.last   = final_q && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ring_q  <= '0;
            idx_q   <= '0;
            hold_q  <= '0;
            left_q  <= '0;
            final_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        ring_q  <= req_ring_i;
                        idx_q   <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    hold_q  <= aligned_i;
                    left_q  <= count_i;
                    final_q <= final_entry;
                    if (count_i != '0) begin
                        state_q <= ST_EMIT;
                    end else if (final_entry) begin
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (!full_i) begin
                        hold_q <= hold_q >> VW;
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            if (final_q) begin
                                state_q <= ST_IDLE;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                state_q <= ST_LOAD;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/string_gather_reader.sv
module string_gather_reader
    import sgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_wr_en,
    input  logic [ADDR_W-1:0] word_wr_addr,
    input  logic [WORD_W-1:0] word_wr_data,
    input  logic              map_wr_en,
    input  logic [RING_W-1:0] map_wr_ring,
    input  logic [IDX_W-1:0]  map_wr_idx,
    input  logic [ADDR_W-1:0] map_wr_addr,
    input  logic [SLOTS-1:0]  map_wr_mask,
    input  logic              map_wr_end,
    input  logic              req_valid,
    input  logic [RING_W-1:0] req_ring,
    output logic              busy,
    output logic              out_valid,
    output logic [VW-1:0]     out_vertex,
    output logic              out_last,
    input  logic              out_ready
);

    logic [WORD_W-1:0] vmem_q [MEM_WORDS];
    map_entry_t        map_q  [NUM_RINGS][MAP_LEN];

    logic [RING_W-1:0] w_ring;
    logic [IDX_W-1:0]  w_idx;
    map_entry_t        w_entry;
    logic [WORD_W-1:0] w_word;
    logic [WORD_W-1:0] w_aligned;
    logic [CNT_W-1:0]  w_count;
    logic              w_full;
    logic              w_push;
    logic              w_push_last;
    out_item_t         w_item;
    out_item_t         w_head;

    always_ff @(posedge clk) begin
        if (word_wr_en) vmem_q[word_wr_addr] <= word_wr_data;
    end

    always_ff @(posedge clk) begin
        if (map_wr_en) begin
            map_q[map_wr_ring][map_wr_idx] <= '{fin: map_wr_end, addr: map_wr_addr, mask: map_wr_mask};
        end
    end

    assign w_entry     = map_q[w_ring][w_idx];
    assign w_word      = vmem_q[w_entry.addr];
    assign w_push_last = w_item.last;

    sgr_slot_compactor u_compact (
        .word_i    (w_word),
        .mask_i    (w_entry.mask),
        .aligned_o (w_aligned),
        .count_o   (w_count)
    );

    sgr_walker u_walk (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_ring_i  (req_ring),
        .entry_i     (w_entry),
        .aligned_i   (w_aligned),
        .count_i     (w_count),
        .full_i      (w_full),
        .ring_o      (w_ring),
        .idx_o       (w_idx),
        .busy_o      (busy),
        .push_o      (w_push),
        .item_o      (w_item)
    );

    sgr_out_fifo u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (w_push),
        .item_i  (w_item),
        .pop_i   (out_ready),
        .head_o  (w_head),
        .valid_o (out_valid),
        .full_o  (w_full)
    );

    assign out_vertex = w_head.vertex;
    assign out_last   = w_head.last;

endmodule

// File: rtl/sgr_checker.sv
module sgr_checker
    import sgr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VW-1:0]     out_vertex,
    input logic              out_last,
    input logic              push,
    input logic              push_last,
    input logic [RING_W-1:0] cur_ring
);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !out_valid)); // R1

    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(cur_ring)); // R2

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy); // R8

    AST_LAST_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
        (push && push_last) |=> !busy); // R5

    AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (rst)
        push |=> out_valid); // R6

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vertex) && $stable(out_last))); // R7

endmodule

bind string_gather_reader sgr_checker u_sgr_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_vertex (out_vertex),
    .out_last   (out_last),
    .push       (w_push),
    .push_last  (w_push_last),
    .cur_ring   (w_ring)
);

// File: tb/test_string_gather_reader.sv
`timescale 1ns/1ps
module test_string_gather_reader;
    import sgr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              word_wr_en = 1'b0;
    logic [ADDR_W-1:0] word_wr_addr = '0;
    logic [WORD_W-1:0] word_wr_data = '0;
    logic              map_wr_en = 1'b0;
    logic [RING_W-1:0] map_wr_ring = '0;
    logic [IDX_W-1:0]  map_wr_idx = '0;
    logic [ADDR_W-1:0] map_wr_addr = '0;
    logic [SLOTS-1:0]  map_wr_mask = '0;
    logic              map_wr_end = 1'b0;
    logic              req_valid = 1'b0;
    logic [RING_W-1:0] req_ring = '0;
    logic              busy;
    logic              out_valid;
    logic [VW-1:0]     out_vertex;
    logic              out_last;
    logic              out_ready = 1'b1;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int ready_mode = 0;

    int exp_v[$];
    bit exp_l[$];

    logic [VW-1:0]     bw    [MEM_WORDS][SLOTS];
    logic [SLOTS-1:0]  bmask [NUM_RINGS][MAP_LEN];
    logic [ADDR_W-1:0] baddr [NUM_RINGS][MAP_LEN];
    bit                bend  [NUM_RINGS][MAP_LEN];

    string_gather_reader i_string_gather_reader (
        .clk(clk), .rst(rst),
        .word_wr_en(word_wr_en), .word_wr_addr(word_wr_addr), .word_wr_data(word_wr_data),
        .map_wr_en(map_wr_en), .map_wr_ring(map_wr_ring), .map_wr_idx(map_wr_idx),
        .map_wr_addr(map_wr_addr), .map_wr_mask(map_wr_mask), .map_wr_end(map_wr_end),
        .req_valid(req_valid), .req_ring(req_ring), .busy(busy),
        .out_valid(out_valid), .out_vertex(out_vertex), .out_last(out_last),
        .out_ready(out_ready)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // ready driver, just after each rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // reference comparison at every falling edge (R3 R4 R5 R7)
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_v.size() == 0) begin
                chk(1'b0, "R2 unexpected vertex", int'(out_vertex), -1);
            end else begin
                chk(out_vertex == exp_v[0], "R3/R4 vertex order", int'(out_vertex), exp_v[0]);
                chk(out_last == exp_l[0], "R5 end flag", int'(out_last), int'(exp_l[0]));
                void'(exp_v.pop_front());
                void'(exp_l.pop_front());
            end
        end
    end

    task automatic write_word(input int a);
        @(posedge clk); #2;
        word_wr_en = 1'b1;
        word_wr_addr = ADDR_W'(a);
        for (int k = 0; k < SLOTS; k++) word_wr_data[k*VW +: VW] = bw[a][k];
        @(posedge clk); #2;
        word_wr_en = 1'b0;
    endtask

    task automatic write_map(input int r, input int i, input int a, input int m, input bit e);
        baddr[r][i] = ADDR_W'(a);
        bmask[r][i] = SLOTS'(m);
        bend[r][i]  = e;
        @(posedge clk); #2;
        map_wr_en = 1'b1;
        map_wr_ring = RING_W'(r);
        map_wr_idx = IDX_W'(i);
        map_wr_addr = ADDR_W'(a);
        map_wr_mask = SLOTS'(m);
        map_wr_end = e;
        @(posedge clk); #2;
        map_wr_en = 1'b0;
    endtask

    task automatic add_expected(input int r);
        int n0;
        n0 = exp_v.size();
        for (int i = 0; i < MAP_LEN; i++) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (bmask[r][i][k]) begin
                    exp_v.push_back(int'(bw[baddr[r][i]][k]));
                    exp_l.push_back(1'b0);
                end
            end
            if (bend[r][i]) break;
        end
        if (exp_l.size() > n0) exp_l[exp_l.size()-1] = 1'b1;
    endtask

    // drives the request; returns just after the accepting edge (+2 ns)
    task automatic request(input int r, input bit expect_accept);
        @(posedge clk); #2;
        req_valid = 1'b1;
        req_ring = RING_W'(r);
        if (expect_accept) add_expected(r);
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || out_valid || exp_v.size() != 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < MEM_WORDS; a++)
            for (int k = 0; k < SLOTS; k++) bw[a][k] = VW'(a * 16 + k);
        for (int r = 0; r < NUM_RINGS; r++)
            for (int i = 0; i < MAP_LEN; i++) begin
                bend[r][i] = 1'b0; bmask[r][i] = '0; baddr[r][i] = '0;
            end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        @(posedge clk); #2;
        rst = 1'b0;

        for (int a = 0; a < MEM_WORDS; a++) write_word(a);
        write_map(0, 0, 3, 'h3FF, 1'b1);
        write_map(1, 0, 1, 'h3FF, 1'b0);
        write_map(1, 1, 2, 'h01F, 1'b0);
        write_map(1, 2, 5, 'h3E0, 1'b0);
        write_map(1, 3, 7, 'h00C, 1'b1);
        write_map(2, 0, 4, 'h000, 1'b0);
        write_map(2, 1, 9, 'h200, 1'b1);
        for (int i = 0; i < MAP_LEN; i++) write_map(3, i, i, 1 << (i % SLOTS), i == MAP_LEN - 1);
        write_map(4, 0, 6, 'h0F0, 1'b1);

        // R6 R8: latency and streaming of a full word
        ready_mode = 0;
        request(0, 1'b1);
        @(negedge clk);
        chk(busy, "R8 busy after accepting edge", int'(busy), 1);
        @(negedge clk);
        chk(!out_valid, "R6 no vertex one cycle after accept", int'(out_valid), 0);
        for (int n = 0; n < SLOTS; n++) begin
            @(negedge clk);
            chk(out_valid, "R6 consecutive vertex", int'(out_valid), 1);
        end
        chk(!busy, "R8 busy falls after final push", int'(busy), 0);
        wait_idle();

        // R3 R4 R2: multi-entry ring under backpressure, request while busy
        ready_mode = 1;
        request(1, 1'b1);
        repeat (3) @(posedge clk);
        request(4, 1'b0);
        wait_idle();
        repeat (6) @(negedge clk);
        chk(!out_valid, "R2 nothing after ignored request", int'(out_valid), 0);
        chk(exp_v.size() == 0, "R2 all expected vertices seen", exp_v.size(), 0);

        // R7: stall with ready low
        ready_mode = 2;
        request(3, 1'b1);
        repeat (20) @(negedge clk);
        chk(out_valid, "R7 head held while stalled", int'(out_valid), 1);
        chk(out_vertex == exp_v[0], "R7 head vertex", int'(out_vertex), exp_v[0]);
        chk(busy, "R7 walk stalled on full FIFO", int'(busy), 1);
        ready_mode = 1;
        wait_idle();

        // R9: empty-mask entry skipped; R4: middle run aligned
        ready_mode = 0;
        request(2, 1'b1);
        wait_idle();
        request(4, 1'b1);
        wait_idle();
        chk(exp_v.size() == 0, "R9 queue drained", exp_v.size(), 0);

        summary();
        $finish;
    end

endmodule